// File: doc/BRIEF.md
# Five-Level Stacked-Carrier PWM Modulator

This block turns three signed phase references into switch commands for three legs of a five-level neutral-point-clamped inverter. A single up/down counter produces a triangular wave. Four copies of that wave, each shifted by one carrier amplitude, form a stack that runs from minus two amplitudes to plus two amplitudes, with zero in the middle. Each phase reference is compared against all four carriers. The number of carriers lying below the reference picks one of five legal switch states. The upper switches of a leg are driven from that state, and each lower switch is driven as the inverse of its upper partner.

References are captured only at the turning points of the triangle (regular sampling), so they stay fixed while the carrier sweeps. An optional common-mode shift can be applied at capture. It takes the largest and smallest of the three references and subtracts their midpoint from every phase, which pushes the switching events of the three legs towards the middle of each sample interval. The carrier half-period is an input, so the switching frequency can be set at run time.

Top module: `pwm5_modulator`

## Requirements
- R1: While reset is low, and in the first cycle after it, every leg shows upper 4'b0011 and lower 4'b1100. The carrier counter restarts at 0 in the falling direction, so the first clock after reset is a turning point.
- R2: The counter t steps by exactly one each clock. Let H be the half-period (`carrier_half`). Rising with t >= H it turns and falls; falling at t == 0 it turns and rises, so the period is 2H clocks. Carrier k (k = 0..3) equals t + (k-2)*H.
- R3: References and the offset enable are taken only in turning cycles. The held values do not change in any other cycle, whatever the inputs do.
- R4: In each clock, the level n of a leg is the count of carriers k for which the held reference is strictly greater than carrier k. The gate outputs show the pattern for n one clock later.
- R5: The upper bits are laid out as bit 3 = outermost switch S1 down to bit 0 = innermost switch S4. Level n sets the n lowest upper bits: 0000, 0001, 0011, 0111, 1111 for n = 0..4.
- R6: Each lower bit is the inverse of the upper bit at the same position.
- R7: With offset enabled, each captured reference equals the raw reference minus floor((max+min)/2), where max and min are taken over the three raw references.
- R8: With offset disabled, the raw references are captured unchanged, sign-extended by one bit.
- R9: A held reference above 2H gives level 4 (provided t <= H). A held reference at or below -2H gives level 0. Extreme input codes saturate and never wrap.
- R10: A half-period of 0 is treated as 1, which gives a two-clock carrier period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 3*REF_W | Signed phase references; phase p is in bits [p*REF_W +: REF_W] |
| carrier_half | input | CNT_W | Carrier half-period H in clocks (0 acts as 1) |
| offset_en | input | 1 | Enables common-mode offset at capture |
| gate_hi_o | output | 12 | Upper switches; leg p is in bits [4p +: 4], bit 3 = S1 |
| gate_lo_o | output | 12 | Lower switches, same layout as the upper switches |

## Verification
The bench targets several corner cases, each of which a wrong design would show at the gate outputs:
- References changed in every clock. A design that samples continuously would let the gates follow these changes in the middle of a carrier period.
- A reference exactly equal to 2H. This separates a strict compare from a non-strict one, because a non-strict compare gives level 4 at the carrier peak.
- Full-scale codes with and without offset. A design that drops the extra bit would wrap a large positive reference to level 0.
- A half-period of zero, and a half-period reduced while the counter sits above it. A wrong design would stall the counter or run it past the new peak.
- A reset in the middle of a run. This shows whether the gates return to the zero-level pattern and whether the carrier phase restarts.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;
  localparam int NPH  = 3;
  localparam int NCAR = 4;

  typedef logic [NCAR-1:0] sw_t;

  // Upper-switch pattern: bit 3 = S1 (outermost), bit 0 = S4.
  function automatic sw_t upper_pat(input logic [2:0] lvl);
    case (lvl)
      3'd0:    return 4'b0000;
      3'd1:    return 4'b0001;
      3'd2:    return 4'b0011;
      3'd3:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  // Lower-switch pattern, held in its own table.
  function automatic sw_t lower_pat(input logic [2:0] lvl);
    case (lvl)
      3'd0:    return 4'b1111;
      3'd1:    return 4'b1110;
      3'd2:    return 4'b1100;
      3'd3:    return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/pwm5_carrier.sv
module pwm5_carrier #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] half_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] hp_o,
  output logic             turn_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             up_q;
  logic [CNT_W-1:0] hp;

  assign hp     = (half_i == '0) ? CNT_W'(1) : half_i;
  assign turn_o = up_q ? (cnt_q >= hp) : (cnt_q == '0);
  assign cnt_o  = cnt_q;
  assign hp_o   = hp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
    end else if (turn_o) begin
      if (up_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
        up_q  <= 1'b0;
      end else begin
        cnt_q <= CNT_W'(1);
        up_q  <= 1'b1;
      end
    end else if (up_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R2: counter moves by exactly one each clock
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == $past(cnt_q) - CNT_W'(1))));

  // R2: rising counter at or past the peak falls next
  a_r2_peak_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && cnt_q >= hp) |=> (cnt_q < $past(cnt_q)));

  // R2: falling counter at zero rises next
  a_r2_floor_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_q && cnt_q == '0) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/pwm5_sampler.sv
module pwm5_sampler
  import pwm5_pkg::*;
#(
  parameter int REF_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPH*REF_W-1:0]     ref_i,
  input  logic                     ofs_en_i,
  input  logic                     take_i,
  output logic [NPH*(REF_W+1)-1:0] ref_o
);
  localparam int AW = REF_W + 1;

  logic signed [AW-1:0] raw    [NPH];
  logic signed [AW-1:0] adj    [NPH];
  logic signed [AW-1:0] hold_q [NPH];
  logic [NPH*AW-1:0]    raw_pk;
  logic signed [AW-1:0] mx, mn, shift;
  logic signed [AW:0]   mid_sum;

  always_comb begin
    for (int p = 0; p < NPH; p++)
      raw[p] = {ref_i[p*REF_W+REF_W-1], ref_i[p*REF_W +: REF_W]};
    mx = raw[0];
    mn = raw[0];
    for (int p = 1; p < NPH; p++) begin
      if (raw[p] > mx) mx = raw[p];
      if (raw[p] < mn) mn = raw[p];
    end
    mid_sum = {mx[AW-1], mx} + {mn[AW-1], mn};
    shift   = mid_sum[AW:1];
    for (int p = 0; p < NPH; p++)
      adj[p] = ofs_en_i ? (raw[p] - shift) : raw[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPH; p++) hold_q[p] <= '0;
    end else if (take_i) begin
      for (int p = 0; p < NPH; p++) hold_q[p] <= adj[p];
    end
  end

  for (genvar p = 0; p < NPH; p++) begin : g_pack
    assign ref_o[p*AW +: AW]  = hold_q[p];
    assign raw_pk[p*AW +: AW] = raw[p];
  end

  // Checker-side view of the held extremes
  logic signed [AW-1:0] hmax, hmin;
  logic signed [AW:0]   chk_sum;
  always_comb begin
    hmax = hold_q[0];
    hmin = hold_q[0];
    for (int p = 1; p < NPH; p++) begin
      if (hold_q[p] > hmax) hmax = hold_q[p];
      if (hold_q[p] < hmin) hmin = hold_q[p];
    end
    chk_sum = {hmax[AW-1], hmax} + {hmin[AW-1], hmin};
  end

  // R3: held references change only after a turning cycle
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> $stable(ref_o));

  // R7: after an offset capture, held max and min are centred on zero
  a_r7_centred: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && ofs_en_i) |=> (chk_sum == '0 || chk_sum == (AW+1)'(1)));

  // R8: without offset the raw values are captured
  a_r8_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !ofs_en_i) |=> (ref_o == $past(raw_pk)));
endmodule

// File: rtl/pwm5_leg.sv
module pwm5_leg
  import pwm5_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CNT_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic signed [REF_W:0] ref_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [CNT_W-1:0]   hp_i,
  output sw_t                hi_o,
  output sw_t                lo_o
);
  localparam int CW = (REF_W + 2 > CNT_W + 4) ? REF_W + 2 : CNT_W + 4;

  logic signed [CW-1:0] ref_x, cnt_x, hp_x, hp2;
  logic signed [CW-1:0] car [NCAR];
  logic [NCAR-1:0]      above;
  logic [2:0]           lvl;
  sw_t                  hi_q, lo_q;

  assign ref_x = CW'(ref_i);
  assign cnt_x = signed'(CW'(cnt_i));
  assign hp_x  = signed'(CW'(hp_i));
  assign hp2   = hp_x <<< 1;

  for (genvar k = 0; k < NCAR; k++) begin : g_car
    assign car[k]   = cnt_x + CW'(k - 2) * hp_x;
    assign above[k] = ref_x > car[k];
  end

  always_comb begin
    lvl = 3'd0;
    for (int k = 0; k < NCAR; k++)
      if (above[k]) lvl = lvl + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 4'b0011;
      lo_q <= 4'b1100;
    end else begin
      hi_q <= upper_pat(lvl);
      lo_q <= lower_pat(lvl);
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // R6: each lower switch opposes its upper partner
  a_r6_complement: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q ^ lo_q) == 4'b1111);

  // R5: upper pattern is a thermometer from S4 outward
  a_r5_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q & (hi_q + 4'd1)) == 4'b0000);

  // R4: a higher carrier is exceeded only if all lower ones are
  for (genvar k = 0; k < NCAR - 1; k++) begin : g_ord
    a_r4_stack_order: assert property (@(posedge clk) disable iff (!rst_n)
      above[k+1] |-> above[k]);
  end

  // R9: saturation at both ends
  a_r9_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_x > hp2 && cnt_x <= hp_x) |=> (hi_q == 4'b1111));
  a_r9_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_x <= -hp2) |=> (hi_q == 4'b0000));
endmodule

// File: rtl/pwm5_modulator.sv
module pwm5_modulator
  import pwm5_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CNT_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPH*REF_W-1:0] ref_i,
  input  logic [CNT_W-1:0]     carrier_half,
  input  logic                 offset_en,
  output logic [NPH*NCAR-1:0]  gate_hi_o,
  output logic [NPH*NCAR-1:0]  gate_lo_o
);
  localparam int AW = REF_W + 1;

  logic [CNT_W-1:0]    cnt, hp;
  logic                turn;
  logic [NPH*AW-1:0]   held;

  pwm5_carrier #(.CNT_W(CNT_W)) u_car (
    .clk(clk), .rst_n(rst_n), .half_i(carrier_half),
    .cnt_o(cnt), .hp_o(hp), .turn_o(turn)
  );

  pwm5_sampler #(.REF_W(REF_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .ofs_en_i(offset_en),
    .take_i(turn), .ref_o(held)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_leg
    pwm5_leg #(.REF_W(REF_W), .CNT_W(CNT_W)) u_leg (
      .clk(clk), .rst_n(rst_n),
      .ref_i(held[p*AW +: AW]),
      .cnt_i(cnt), .hp_i(hp),
      .hi_o(gate_hi_o[p*NCAR +: NCAR]),
      .lo_o(gate_lo_o[p*NCAR +: NCAR])
    );
  end
endmodule

// File: tb/sim_pwm5_modulator.sv
module sim_pwm5_modulator;
  localparam int CLK_NS = 10;
  localparam int RW = 12;
  localparam int CWD = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [3*RW-1:0] ref_i = '0;
  logic [CWD-1:0]  carrier_half = 10'd8;
  logic            offset_en = 1'b0;
  logic [11:0]     gate_hi_o, gate_lo_o;

  int    n_chk = 0, n_err = 0, cyc = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";

  // Behavioural model state
  int m_t = 0;
  bit m_up = 0;
  int m_ref [3] = '{0, 0, 0};
  int m_lvl [3] = '{2, 2, 2};

  pwm5_modulator u0 (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .carrier_half(carrier_half),
    .offset_en(offset_en), .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o)
  );

  initial forever #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int sx(input logic [RW-1:0] v);
    return v[RW-1] ? int'(v) - (1 << RW) : int'(v);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t = 0; m_up = 0;
      for (int p = 0; p < 3; p++) begin m_ref[p] = 0; m_lvl[p] = 2; end
    end else begin
      int h, v [3], mx, mn, s;
      bit turn;
      h = (carrier_half == 0) ? 1 : int'(carrier_half);
      for (int p = 0; p < 3; p++) begin
        m_lvl[p] = 0;
        for (int k = 0; k < 4; k++)
          if (m_ref[p] > m_t + (k - 2) * h) m_lvl[p]++;
      end
      turn = m_up ? (m_t >= h) : (m_t == 0);
      if (turn) begin
        for (int p = 0; p < 3; p++) v[p] = sx(ref_i[p*RW +: RW]);
        mx = v[0]; mn = v[0];
        for (int p = 1; p < 3; p++) begin
          if (v[p] > mx) mx = v[p];
          if (v[p] < mn) mn = v[p];
        end
        s = offset_en ? ((mx + mn) >>> 1) : 0;
        for (int p = 0; p < 3; p++) m_ref[p] = v[p] - s;
      end
      if (turn) begin
        if (m_up) begin m_t = m_t - 1; m_up = 0; end
        else begin m_t = 1; m_up = 1; end
      end else m_t = m_up ? m_t + 1 : m_t - 1;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      for (int p = 0; p < 3; p++) begin
        int e;
        e = (1 << m_lvl[p]) - 1;
        chk(cur_req, int'(gate_hi_o[p*4 +: 4]), e, $sformatf("leg%0d upper", p));
        chk("R6", int'(gate_lo_o[p*4 +: 4]), 15 ^ e, $sformatf("leg%0d lower", p));
      end
    end
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic set_refs(input int a, input int b, input int c);
    ref_i = {RW'(c), RW'(b), RW'(a)};
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    set_refs(0, 0, 0);
    run(3);
    // R1: reset state on every leg
    for (int p = 0; p < 3; p++) begin
      chk("R1", int'(gate_hi_o[p*4 +: 4]), 3, "reset upper");
      chk("R1", int'(gate_lo_o[p*4 +: 4]), 12, "reset lower");
    end
    #1 rst_n = 1'b1;
    cmp_on = 1;

    cur_req = "R4"; set_refs(5, -7, 13); run(40);
    cur_req = "R2"; set_refs(0, 9, -15); run(40);

    cur_req = "R3";
    for (int i = 0; i < 60; i++) begin
      set_refs(((i * 5) % 33) - 16, ((i * 7) % 29) - 14, 16 - ((i * 3) % 31));
      run(1);
    end

    cur_req = "R7"; offset_en = 1;
    for (int i = 0; i < 60; i++) begin
      set_refs(10 + (i % 7), -3 - (i % 5), 14 - (i % 9));
      run(1);
    end
    set_refs(2047, -2048, 0); run(20);
    set_refs(2047, 2046, 2045); run(20);

    cur_req = "R8"; offset_en = 0;
    for (int i = 0; i < 40; i++) begin
      set_refs(12 - (i % 25), (i % 11) - 5, -(i % 17));
      run(1);
    end

    cur_req = "R9"; set_refs(2047, -2048, 16); run(40);
    set_refs(17, -16, -17); run(40);

    cur_req = "R5"; carrier_half = 10'd4;
    for (int i = 0; i < 18; i++) begin
      set_refs(-9 + i, 9 - i, i - 4);
      run(8);
    end

    cur_req = "R10"; carrier_half = 10'd0; set_refs(1, 0, -1); run(20);
    carrier_half = 10'd1; set_refs(2, -1, 1); run(20);

    cur_req = "R2"; carrier_half = 10'd50;
    for (int i = 0; i < 400; i++) begin
      int ph;
      ph = i % 120;
      set_refs((ph < 60 ? ph : 120 - ph) * 3 - 90, 90 - (ph < 60 ? ph : 120 - ph) * 3, (i % 200) - 100);
      run(1);
    end
    carrier_half = 10'd5; run(120);

    cur_req = "R1";
    @(negedge clk); #1 rst_n = 1'b0;
    run(3);
    #1 rst_n = 1'b1;
    set_refs(3, -4, 8); carrier_half = 10'd6; run(60);

    cmp_on = 0;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule